// File: doc/BRIEF.md
# Stack-Distance Cache Profiler

This block sits beside one core's path into the last-level cache and watches its reference stream. It does not hold data. For a thinned-out group of sets it keeps a shadow directory of short hashed tags. Each such set is kept as a strict recency list, and the list can hold more entries than the real cache gives one core. For every reference it tracks, the block finds how far down the list the tag sits, counted from the most-recent end, and bumps the counter for that depth.

The counters hold a histogram of reuse distance. A partition allocator can read them and get the miss count for any way budget k from one run: subtract the sum of the counters for depths 0 to k-1 from the count of tracked references. A reference whose tag is absent is a miss and enters at the most-recent end. When the list is full, the least-recent tag is thrown away and an eviction counter records it.

Top module: `sdp_profiler`

## Requirements
- R1: The address is split as follows: offset in bits [5:0], set index in bits [15:6], hashed tag in bits [27:16]. A set is tracked only when set-index bits [4:0] are all zero, and its list slot is address bits [15:11]. Address bits [31:28] take no part, so tags that agree in bits [27:16] alias to one entry.
- R2: An access is profiled only when acc_core equals PROFILE_CORE and the set is tracked. Any other access leaves every counter unchanged.
- R3: A profiled hit at depth d increments hit counter d. Depth 0 is the most recent entry. The deepest reachable depth is DEPTH-1 (default 71).
- R4: After any profiled access, the referenced tag is at depth 0. Entries that were above its old position each move one step deeper, and entries below it keep their depth.
- R5: A profiled miss inserts its tag at depth 0. The total counter increments on every profiled access, hit or miss.
- R6: A miss on a list already holding DEPTH tags drops the deepest tag and increments the eviction counter. Filling a list to exactly DEPTH tags evicts nothing. A dropped tag misses when referenced again.
- R7: rd_data is combinational in rd_idx. Indices below DEPTH return that hit counter, index DEPTH returns the total counter, index DEPTH+1 returns the eviction counter, and any larger index returns zero.
- R8: An access accepted at a rising edge shows in the counters after the next rising edge, and not before.
- R9: acc_ready is low exactly when the presented access is profiled and targets the same list slot as the profiled access accepted at the previous edge. In all other cases it is high.
- R10: clr, sampled at a rising edge, empties every list and zeroes every counter. Reset does the same.
- R11: Lists in different slots are independent. A tag's history in one slot does not affect a lookup in another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of lists and counters |
| acc_valid | input | 1 | Access strobe |
| acc_ready | output | 1 | Access may be accepted this cycle |
| acc_core | input | 3 | Core issuing the access |
| acc_addr | input | 32 | Byte address of the access |
| rd_idx | input | 7 | Counter select |
| rd_data | output | 32 | Selected counter value |

## Verification
Two cases are the hardest to reach from the ports. The first is a hit at the deepest depth. The second is an eviction that is followed by a miss on the tag that was thrown out. Both need one slot filled with exactly DEPTH distinct tags in a known order. The bench loops in 72 distinct tags, re-references the oldest one to hit at depth 71, then adds one new tag to force a drop, and re-touches the dropped tag. Backpressure is reached by holding the strobe across two back-to-back accesses to one slot and sampling acc_ready in the second cycle. That case is contrasted with back-to-back accesses to different slots and with a same-slot access from another core.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;

  // saturating increment
  function automatic cnt_t sat_inc(cnt_t v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  // deepest position that shifts on an update
  function automatic int shift_limit(logic hit, int pos, int depth);
    return hit ? pos : depth - 1;
  endfunction
endpackage

// File: rtl/sdp_decode.sv
module sdp_decode #(
  parameter int ADDR_W       = 32,
  parameter int OFFSET_W     = 6,
  parameter int SET_W        = 10,
  parameter int SAMPLE_W     = 5,
  parameter int PTAG_W       = 12,
  parameter int CORE_W       = 3,
  parameter int PROFILE_CORE = 0,
  localparam int SLOT_W      = SET_W - SAMPLE_W
) (
  input  logic [CORE_W-1:0] core,
  input  logic [ADDR_W-1:0] addr,
  output logic              profiled,
  output logic [SLOT_W-1:0] slot,
  output logic [PTAG_W-1:0] ptag
);
  logic [SET_W-1:0] set_idx;
  assign set_idx  = addr[OFFSET_W +: SET_W];
  assign slot     = set_idx[SET_W-1:SAMPLE_W];
  assign ptag     = addr[OFFSET_W+SET_W +: PTAG_W];
  assign profiled = (core == CORE_W'(PROFILE_CORE)) && (set_idx[SAMPLE_W-1:0] == '0);
endmodule

// File: rtl/sdp_stack.sv
module sdp_stack #(
  parameter int SLOTS  = 32,
  parameter int DEPTH  = 72,
  parameter int PTAG_W = 12,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int POS_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [PTAG_W-1:0] lk_tag,
  output logic              lk_hit,
  output logic [POS_W-1:0]  lk_pos,
  input  logic              up_en,
  input  logic [SLOT_W-1:0] up_slot,
  input  logic [PTAG_W-1:0] up_tag,
  input  logic              up_hit,
  input  logic [POS_W-1:0]  up_pos,
  output logic              up_full
);
  import sdp_pkg::*;

  logic [PTAG_W-1:0] ent  [SLOTS][DEPTH];
  logic [FILL_W-1:0] fill [SLOTS];
  int                lim;

  always_comb begin
    lk_hit = 1'b0;
    lk_pos = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((FILL_W'(i) < fill[lk_slot]) && (ent[lk_slot][i] == lk_tag)) begin
        lk_hit = 1'b1;
        lk_pos = POS_W'(i);
      end
    end
  end

  assign up_full = (fill[up_slot] == FILL_W'(DEPTH));
  assign lim     = shift_limit(up_hit, int'(up_pos), DEPTH);

  // recency list contents (validity comes from fill)
  always_ff @(posedge clk) begin
    if (up_en && !clr) begin
      ent[up_slot][0] <= up_tag;
      for (int i = 1; i < DEPTH; i++) begin
        if (i <= lim) ent[up_slot][i] <= ent[up_slot][i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) fill[s] <= '0;
    end else if (clr) begin
      for (int s = 0; s < SLOTS; s++) fill[s] <= '0;
    end else if (up_en && !up_hit && !up_full) begin
      fill[up_slot] <= fill[up_slot] + 1'b1;
    end
  end
endmodule

// File: rtl/sdp_counters.sv
module sdp_counters #(
  parameter int DEPTH = 72,
  localparam int POS_W = $clog2(DEPTH),
  localparam int IDX_W = $clog2(DEPTH + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   up_en,
  input  logic                   up_hit,
  input  logic [POS_W-1:0]       up_pos,
  input  logic                   up_evict,
  input  logic [IDX_W-1:0]       rd_idx,
  output sdp_pkg::cnt_t          rd_data,
  output sdp_pkg::cnt_t          total_q,
  output sdp_pkg::cnt_t          evict_q
);
  import sdp_pkg::*;

  cnt_t hits [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hits[i] <= '0;
      total_q <= '0;
      evict_q <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) hits[i] <= '0;
      total_q <= '0;
      evict_q <= '0;
    end else if (up_en) begin
      total_q <= sat_inc(total_q);
      if (up_evict) evict_q <= sat_inc(evict_q);
      for (int i = 0; i < DEPTH; i++) begin
        if (up_hit && (up_pos == POS_W'(i))) hits[i] <= sat_inc(hits[i]);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx < IDX_W'(DEPTH))           rd_data = hits[rd_idx[POS_W-1:0]];
    else if (rd_idx == IDX_W'(DEPTH))     rd_data = total_q;
    else if (rd_idx == IDX_W'(DEPTH + 1)) rd_data = evict_q;
  end
endmodule

// File: rtl/sdp_profiler.sv
module sdp_profiler #(
  parameter int ADDR_W       = 32,
  parameter int OFFSET_W     = 6,
  parameter int SET_W        = 10,
  parameter int SAMPLE_W     = 5,
  parameter int PTAG_W       = 12,
  parameter int CORE_W       = 3,
  parameter int PROFILE_CORE = 0,
  parameter int DEPTH        = 72,
  localparam int SLOT_W      = SET_W - SAMPLE_W,
  localparam int SLOTS       = 1 << SLOT_W,
  localparam int POS_W       = $clog2(DEPTH),
  localparam int IDX_W       = $clog2(DEPTH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [CORE_W-1:0] acc_core,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data
);
  import sdp_pkg::*;

  logic              in_prof;
  logic [SLOT_W-1:0] in_slot;
  logic [PTAG_W-1:0] in_tag;
  logic              lk_hit;
  logic [POS_W-1:0]  lk_pos;
  logic              take;

  logic              pend_v;
  logic [SLOT_W-1:0] pend_slot;
  logic [PTAG_W-1:0] pend_tag;
  logic              pend_hit;
  logic [POS_W-1:0]  pend_pos;

  // named events for the checker
  logic upd_fire, upd_hit, upd_full, upd_evict;
  cnt_t total_cnt, evict_cnt, rd_word;

  sdp_decode #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SET_W(SET_W), .SAMPLE_W(SAMPLE_W),
    .PTAG_W(PTAG_W), .CORE_W(CORE_W), .PROFILE_CORE(PROFILE_CORE)
  ) u_dec (
    .core(acc_core), .addr(acc_addr),
    .profiled(in_prof), .slot(in_slot), .ptag(in_tag)
  );

  assign acc_ready = !(pend_v && in_prof && (in_slot == pend_slot));
  assign take      = acc_valid && acc_ready && in_prof && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_slot <= '0;
      pend_tag  <= '0;
      pend_hit  <= 1'b0;
      pend_pos  <= '0;
    end else begin
      pend_v <= take;
      if (take) begin
        pend_slot <= in_slot;
        pend_tag  <= in_tag;
        pend_hit  <= lk_hit;
        pend_pos  <= lk_pos;
      end
    end
  end

  assign upd_fire  = pend_v && !clr;
  assign upd_hit   = pend_hit;
  assign upd_evict = upd_fire && !pend_hit && upd_full;

  sdp_stack #(.SLOTS(SLOTS), .DEPTH(DEPTH), .PTAG_W(PTAG_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .lk_slot(in_slot), .lk_tag(in_tag), .lk_hit(lk_hit), .lk_pos(lk_pos),
    .up_en(upd_fire), .up_slot(pend_slot), .up_tag(pend_tag),
    .up_hit(pend_hit), .up_pos(pend_pos), .up_full(upd_full)
  );

  sdp_counters #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .up_en(upd_fire), .up_hit(pend_hit), .up_pos(pend_pos), .up_evict(upd_evict),
    .rd_idx(rd_idx), .rd_data(rd_word), .total_q(total_cnt), .evict_q(evict_cnt)
  );

  assign rd_data = rd_word;
endmodule

// File: rtl/sdp_profiler_chk.sv
module sdp_profiler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        acc_ready,
  input logic        pend_v,
  input logic        upd_fire,
  input logic        upd_hit,
  input logic        upd_full,
  input logic [31:0] total_cnt,
  input logic [31:0] evict_cnt
);
  // stall only while an earlier profiled access is still pending
  assert_stall_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> pend_v);

  // no pending update means no movement of the total
  assert_total_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_fire && !clr) |=> $stable(total_cnt));

  // each update adds exactly one to the total
  assert_total_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && total_cnt != 32'hFFFF_FFFF) |=> (total_cnt == $past(total_cnt) + 32'd1));

  // evictions only on a miss into a full list
  assert_evict_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(upd_fire && !upd_hit && upd_full)) |=> $stable(evict_cnt));

  // clear zeroes the readable totals
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (total_cnt == 32'd0 && evict_cnt == 32'd0));
endmodule

bind sdp_profiler sdp_profiler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .acc_ready(acc_ready), .pend_v(pend_v),
  .upd_fire(upd_fire), .upd_hit(upd_hit), .upd_full(upd_full),
  .total_cnt(total_cnt), .evict_cnt(evict_cnt)
);

// File: tb/sdp_profiler_tb.sv
module sdp_profiler_tb;
  localparam int DEPTH = 72;
  localparam int NV    = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [2:0]  acc_core = 3'd0;
  logic [31:0] acc_addr = '0;
  logic [6:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  int exp_hit [DEPTH];
  int exp_total = 0;
  int exp_evict = 0;
  logic [31:0] v;

  // {slot, tag16, depth or FF for miss}
  localparam logic [28:0] VEC [NV] = '{
    {5'd0, 16'h0A11, 8'hFF}, {5'd0, 16'h0B22, 8'hFF}, {5'd0, 16'h0A11, 8'd1},
    {5'd0, 16'h0A11, 8'd0},  {5'd0, 16'h0C33, 8'hFF}, {5'd0, 16'h0B22, 8'd2},
    {5'd1, 16'h0A11, 8'hFF}, {5'd0, 16'h0A11, 8'd2},  {5'd1, 16'h0A11, 8'd0},
    {5'd0, 16'h0D44, 8'hFF}, {5'd0, 16'h0C33, 8'd3},  {5'd2, 16'h0A00, 8'hFF},
    {5'd2, 16'h7A00, 8'd0}
  };

  sdp_profiler u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_core(acc_core), .acc_addr(acc_addr), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk(input logic [4:0] slot, input logic [15:0] tag,
                                     input logic [4:0] low);
    return {tag, slot, low, 6'h15};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] val);
    rd_idx = 7'(idx);
    #1;
    val = rd_data;
  endtask

  task automatic issue(input logic [2:0] core, input logic [31:0] addr);
    @(negedge clk);
    acc_valid = 1'b1; acc_core = core; acc_addr = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_hit[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R10)
    rd(0, v);         check(v, 0, "R10 reset hit0");
    rd(DEPTH, v);     check(v, 0, "R10 reset total");
    rd(DEPTH + 1, v); check(v, 0, "R10 reset evict");
    check(acc_ready, 1, "R9 ready after reset");

    // table: R3 R4 R5 R11 R1 alias
    for (int n = 0; n < NV; n++) begin
      logic [7:0] d;
      d = VEC[n][7:0];
      issue(3'd0, mk(VEC[n][28:24], VEC[n][23:8], 5'd0));
      exp_total++;
      if (d != 8'hFF) exp_hit[d]++;
      rd(DEPTH, v); check(v, 32'(exp_total), "R5 total per vector");
      if (d != 8'hFF) begin
        rd(int'(d), v); check(v, 32'(exp_hit[d]), "R3 R4 R11 depth counter");
      end else begin
        rd(0, v); check(v, 32'(exp_hit[0]), "R5 miss leaves hit0");
      end
    end
    rd(0, v); check(v, 3, "R1 alias hit counted at depth 0");

    // ignored accesses (R2, R1)
    issue(3'd0, mk(5'd0, 16'h0A11, 5'd3));
    issue(3'd4, mk(5'd0, 16'h0A11, 5'd0));
    rd(DEPTH, v); check(v, 32'(exp_total), "R2 ignored total");
    for (int i = 0; i < 4; i++) begin
      rd(i, v); check(v, 32'(exp_hit[i]), "R2 ignored hit");
    end

    // readout map (R7)
    rd(DEPTH + 2, v); check(v, 0, "R7 out of range");
    rd(127, v);       check(v, 0, "R7 top index");

    // latency (R8)
    @(negedge clk);
    acc_valid = 1'b1; acc_core = 3'd0; acc_addr = mk(5'd8, 16'h0001, 5'd0);
    @(negedge clk);
    acc_valid = 1'b0;
    rd(DEPTH, v); check(v, 32'(exp_total), "R8 not visible yet");
    @(negedge clk);
    exp_total++;
    rd(DEPTH, v); check(v, 32'(exp_total), "R8 visible after second edge");

    // backpressure (R9)
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = mk(5'd5, 16'h0111, 5'd0);
    #1 check(acc_ready, 1, "R9 first access ready");
    @(negedge clk);
    acc_addr = mk(5'd5, 16'h0222, 5'd0);
    #1 check(acc_ready, 0, "R9 same slot stalls");
    acc_core = 3'd2;
    #1 check(acc_ready, 1, "R9 other core not stalled");
    acc_core = 3'd0;
    @(negedge clk);
    #1 check(acc_ready, 1, "R9 stall lasts one cycle");
    @(negedge clk);
    acc_addr = mk(5'd6, 16'h0333, 5'd0);
    #1 check(acc_ready, 1, "R9 new slot after pending");
    @(negedge clk);
    acc_addr = mk(5'd7, 16'h0444, 5'd0);
    #1 check(acc_ready, 1, "R9 different slot back to back");
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    exp_total += 4;
    rd(DEPTH, v); check(v, 32'(exp_total), "R9 all four accepted");

    // deepest hit and eviction (R3 R6)
    for (int i = 0; i < DEPTH; i++) issue(3'd0, mk(5'd4, 16'(16'h0100 + i), 5'd0));
    exp_total += DEPTH;
    rd(DEPTH + 1, v); check(v, 0, "R6 exactly full no eviction");
    issue(3'd0, mk(5'd4, 16'h0100, 5'd0));
    exp_total++;
    rd(DEPTH - 1, v); check(v, 1, "R3 deepest depth hit");
    issue(3'd0, mk(5'd4, 16'h0300, 5'd0));
    rd(DEPTH + 1, v); check(v, 1, "R6 miss on full evicts");
    issue(3'd0, mk(5'd4, 16'h0101, 5'd0));
    rd(DEPTH + 1, v); check(v, 2, "R6 dropped tag misses");
    rd(DEPTH - 1, v); check(v, 1, "R6 dropped tag no hit");
    issue(3'd0, mk(5'd4, 16'h0300, 5'd0));
    exp_total += 3;
    exp_hit[1]++;
    rd(1, v); check(v, 32'(exp_hit[1]), "R4 shifted entry at depth 1");
    rd(DEPTH, v); check(v, 32'(exp_total), "R5 total after eviction run");

    // clear (R10)
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    rd(DEPTH, v);     check(v, 0, "R10 clear total");
    rd(DEPTH + 1, v); check(v, 0, "R10 clear evict");
    issue(3'd0, mk(5'd0, 16'h0A11, 5'd0));
    rd(DEPTH, v); check(v, 1, "R10 total after clear");
    begin
      int sum = 0;
      for (int i = 0; i < DEPTH; i++) begin
        rd(i, v); sum += int'(v);
      end
      check(32'(sum), 0, "R10 lists emptied by clear");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule